// File: doc/BRIEF.md
# Pipeline Hold and Squash Controller

This block decides, each cycle, how the front end of a five-stage in-order pipeline moves. It freezes the program counter and the fetch/decode register and puts a no-op into the decode/execute register when the instruction in decode needs a result that is not yet available. When a branch or jump resolved in execute turns out taken, it discards the two younger instructions on the wrong path, and the branch itself carries on.

The outputs are combinational decisions taken from the current decode sources and the execute-stage instruction. The controller also keeps two small pieces of state. The first is a one-bit guard that limits a load-use hold to a single cycle. The second, used only when operand forwarding is absent, is a short history of the destinations that have left execute. A build-time parameter picks between the forwarding variant, which holds only behind a load, and the non-forwarding variant, which holds while any of the three older stages still owes a register the decode instruction reads. Forwarding multiplexers and target arithmetic sit elsewhere. The controller only drives the enables, the clear, the bubble and the target-select strobe.

Top module: `pipe_hold_ctrl`

## Requirements
- R1: With no hazard and no taken branch, the control vector {pc_we, pc_load_target, ifid_we, ifid_flush, idex_bubble} is 1,0,1,0,0, including the first cycles after reset is released.
- R2: With FORWARD=1, a hold (vector 0,0,0,0,1) occurs when ex_mem_read and ex_wen are both 1, ex_rd is nonzero, and ex_rd equals a decode source whose use flag is 1. The sources are id_rs1 with id_use_rs1 and id_rs2 with id_use_rs2.
- R3: With FORWARD=1, a hold never lasts longer than one cycle. In the cycle after a hold there is no hold, even if the inputs still match.
- R4: With FORWARD=1, a producer in execute that is not a load (ex_mem_read=0) never causes a hold, and neither does an older producer.
- R5: Register 0 never causes a hold in either variant.
- R6: A source whose use flag is 0 never causes a hold, whatever its field value.
- R7: With FORWARD=0, a hold occurs when a used nonzero source equals one of these: ex_rd with ex_wen=1, or the ex_rd recorded with ex_wen=1 one or two clock cycles earlier.
- R8: With FORWARD=0, a producer recorded three or more cycles earlier no longer holds, and an execute instruction with ex_wen=0 is never recorded.
- R9: When ex_taken=1, the vector is 1,1,0,1,1: the PC loads the target, fetch/decode is cleared, and decode/execute gets a bubble.
- R10: A taken branch wins over a hold in the same cycle. With FORWARD=1, an overridden hold does not count towards R3, so a load-use match in the next cycle still holds.
- R11: While rst_n is low, the one-cycle guard and the destination history are kept clear. A load-use match therefore holds on consecutive reset cycles, and destinations seen during reset never hold later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads id_rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads id_rs2 |
| ex_rd | input | REG_W | Destination register of the instruction in decode/execute |
| ex_wen | input | 1 | Execute instruction writes ex_rd |
| ex_mem_read | input | 1 | Execute instruction is a memory load |
| ex_taken | input | 1 | Branch or jump in execute is taken |
| pc_we | output | 1 | PC update enable |
| pc_load_target | output | 1 | PC takes the resolved target instead of the sequential address |
| ifid_we | output | 1 | Fetch/decode register loads the fetched instruction |
| ifid_flush | output | 1 | Fetch/decode register is cleared to a no-op |
| idex_bubble | output | 1 | Decode/execute register receives a no-op |

## Verification
The hardest cases to reach depend on state the ports never show directly. One is a load-use match that stays on for two cycles, where the second cycle must pass because of the guard. Another is a producer that has left execute, which the non-forwarding variant must still see one and two cycles later. The stimulus reaches these by holding the same decode sources steady over several cycles while the execute inputs change from producer to idle. It also overlaps a taken branch with a live load-use match and then keeps the match for one more cycle. Both variants run side by side on the same inputs, so each sequence exercises the forwarding and non-forwarding rules together.

// File: rtl/pipe_hold_pkg.sv
package pipe_hold_pkg;

  typedef struct packed {
    logic pc_we;
    logic pc_load_target;
    logic ifid_we;
    logic ifid_flush;
    logic idex_bubble;
  } hold_ctrl_t;

  typedef enum logic [1:0] {
    ACT_RUN    = 2'd0,
    ACT_HOLD   = 2'd1,
    ACT_SQUASH = 2'd2
  } hold_act_t;

endpackage

// File: rtl/phc_rst_sync.sv
module phc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/phc_dest_hist.sv
module phc_dest_hist #(
  parameter int REG_W = 5,
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [REG_W-1:0]            in_rd,
  input  logic                        in_wen,
  output logic [DEPTH-1:0][REG_W-1:0] hist_rd
);

  logic [DEPTH-1:0][REG_W-1:0] hist_q;
  logic [DEPTH-1:0][REG_W-1:0] hist_d;

  // A slot holding zero stands for "no pending write"
  always_comb begin
    hist_d[0] = in_wen ? in_rd : '0;
    for (int i = 1; i < DEPTH; i++) begin
      hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist_rd = hist_q;

endmodule

// File: rtl/phc_src_cmp.sv
module phc_src_cmp #(
  parameter int REG_W = 5,
  parameter int NCAND = 1
) (
  input  logic [REG_W-1:0]            src,
  input  logic                        src_used,
  input  logic [NCAND-1:0][REG_W-1:0] cand,
  input  logic [NCAND-1:0]            cand_ok,
  output logic                        hit
);

  logic [NCAND-1:0] eq;

  genvar c;
  generate
    for (c = 0; c < NCAND; c++) begin : g_cand
      assign eq[c] = cand_ok[c] && (cand[c] == src);
    end
  endgenerate

  assign hit = src_used && (src != '0) && (|eq);

endmodule

// File: rtl/phc_action.sv
module phc_action
  import pipe_hold_pkg::*;
(
  input  logic       taken,
  input  logic       hazard,
  output hold_act_t  act,
  output hold_ctrl_t ctrl
);

  always_comb begin
    if (taken)       act = ACT_SQUASH;
    else if (hazard) act = ACT_HOLD;
    else             act = ACT_RUN;
  end

  always_comb begin
    ctrl = '0;
    unique case (act)
      ACT_SQUASH: begin
        ctrl.pc_we          = 1'b1;
        ctrl.pc_load_target = 1'b1;
        ctrl.ifid_flush     = 1'b1;
        ctrl.idex_bubble    = 1'b1;
      end
      ACT_HOLD: begin
        ctrl.idex_bubble    = 1'b1;
      end
      default: begin
        ctrl.pc_we          = 1'b1;
        ctrl.ifid_we        = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pipe_hold_ctrl.sv
module pipe_hold_ctrl
  import pipe_hold_pkg::*;
#(
  parameter bit FORWARD      = 1'b1,
  parameter int REG_W        = 5,
  parameter int TRACK_STAGES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_mem_read,
  input  logic             ex_taken,
  output logic             pc_we,
  output logic             pc_load_target,
  output logic             ifid_we,
  output logic             ifid_flush,
  output logic             idex_bubble
);

  localparam int NSRC  = 2;
  localparam int NCAND = FORWARD ? 1 : TRACK_STAGES + 1;

  logic                        rst_int_n;
  logic [NCAND-1:0][REG_W-1:0] cand;
  logic [NCAND-1:0]            cand_ok;
  logic [NSRC-1:0][REG_W-1:0]  src;
  logic [NSRC-1:0]             src_used;
  logic [NSRC-1:0]             src_hit;
  logic                        raw_hit;
  logic                        hazard;
  logic                        guard_q;
  logic                        guard_d;
  hold_act_t                   act;
  hold_ctrl_t                  ctrl;

  phc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Candidate producers: only a loading execute instruction when values
  // are forwarded, else execute plus the recorded older destinations.
  generate
    if (FORWARD) begin : g_fwd
      assign cand[0]    = ex_rd;
      assign cand_ok[0] = ex_mem_read && ex_wen;
    end else begin : g_nofwd
      logic [TRACK_STAGES-1:0][REG_W-1:0] hist;

      phc_dest_hist #(.REG_W(REG_W), .DEPTH(TRACK_STAGES)) u_hist (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .in_rd   (ex_rd),
        .in_wen  (ex_wen),
        .hist_rd (hist)
      );

      assign cand[0]    = ex_rd;
      assign cand_ok[0] = ex_wen;
      for (genvar h = 0; h < TRACK_STAGES; h++) begin : g_old
        assign cand[h+1]    = hist[h];
        assign cand_ok[h+1] = 1'b1;
      end
    end
  endgenerate

  assign src      = {id_rs2, id_rs1};
  assign src_used = {id_use_rs2, id_use_rs1};

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      phc_src_cmp #(.REG_W(REG_W), .NCAND(NCAND)) u_cmp (
        .src      (src[s]),
        .src_used (src_used[s]),
        .cand     (cand),
        .cand_ok  (cand_ok),
        .hit      (src_hit[s])
      );
    end
  endgenerate

  assign raw_hit = |src_hit;
  assign hazard  = FORWARD ? (raw_hit && !guard_q) : raw_hit;

  phc_action u_action (
    .taken  (ex_taken),
    .hazard (hazard),
    .act    (act),
    .ctrl   (ctrl)
  );

  // Guard remembers an actual hold so a forwarded load never holds twice
  always_comb begin
    guard_d = FORWARD && (act == ACT_HOLD);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) guard_q <= 1'b0;
    else            guard_q <= guard_d;
  end

  assign pc_we          = ctrl.pc_we;
  assign pc_load_target = ctrl.pc_load_target;
  assign ifid_we        = ctrl.ifid_we;
  assign ifid_flush     = ctrl.ifid_flush;
  assign idex_bubble    = ctrl.idex_bubble;

endmodule

// File: rtl/pipe_hold_ctrl_chk.sv
module pipe_hold_ctrl_chk #(
  parameter bit FORWARD = 1'b1,
  parameter int REG_W   = 5
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             id_use_rs1,
  input logic             id_use_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_mem_read,
  input logic             ex_taken,
  input logic             pc_we,
  input logic             pc_load_target,
  input logic             ifid_we,
  input logic             ifid_flush,
  input logic             idex_bubble
);

  // R9
  squash_shape_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ex_taken |-> (pc_we && pc_load_target && ifid_flush && idex_bubble && !ifid_we));

  // R2
  hold_shape_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pc_we |-> (!ifid_we && idex_bubble && !ifid_flush && !pc_load_target));

  // R3
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (FORWARD && !pc_we) |=> pc_we);

  // R4
  no_load_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (FORWARD && !ex_mem_read) |-> pc_we);

  // R6
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!id_use_rs1 && !id_use_rs2) |-> pc_we);

  // R5
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (FORWARD && ex_rd == '0) |-> pc_we);

  // R10
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({!pc_we, ifid_flush}));

  // R9
  target_only_on_taken_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pc_load_target |-> ex_taken);

endmodule

bind pipe_hold_ctrl pipe_hold_ctrl_chk #(.FORWARD(FORWARD), .REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_q_n        (rst_int_n),
  .id_use_rs1     (id_use_rs1),
  .id_use_rs2     (id_use_rs2),
  .ex_rd          (ex_rd),
  .ex_mem_read    (ex_mem_read),
  .ex_taken       (ex_taken),
  .pc_we          (pc_we),
  .pc_load_target (pc_load_target),
  .ifid_we        (ifid_we),
  .ifid_flush     (ifid_flush),
  .idex_bubble    (idex_bubble)
);

// File: tb/pipe_hold_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hold_ctrl_bench;

  localparam int REG_W = 5;

  logic             clk;
  logic             rst_n;
  logic [REG_W-1:0] id_rs1, id_rs2, ex_rd;
  logic             id_use_rs1, id_use_rs2, ex_wen, ex_mem_read, ex_taken;
  logic             f_pc_we, f_tgt, f_ifid_we, f_flush, f_bub;
  logic             n_pc_we, n_tgt, n_ifid_we, n_flush, n_bub;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [4:0] qf[$];
  logic [4:0] qn[$];
  string      qt[$];

  logic             m_prev;
  logic [REG_W-1:0] m_h1, m_h2;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pipe_hold_ctrl #(.FORWARD(1'b1), .REG_W(REG_W)) u_pipe_hold_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mem_read(ex_mem_read), .ex_taken(ex_taken),
    .pc_we(f_pc_we), .pc_load_target(f_tgt), .ifid_we(f_ifid_we),
    .ifid_flush(f_flush), .idex_bubble(f_bub)
  );

  pipe_hold_ctrl #(.FORWARD(1'b0), .REG_W(REG_W)) u_pipe_hold_ctrl_nofwd (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mem_read(ex_mem_read), .ex_taken(ex_taken),
    .pc_we(n_pc_we), .pc_load_target(n_tgt), .ifid_we(n_ifid_we),
    .ifid_flush(n_flush), .idex_bubble(n_bub)
  );

  // Vector order {pc_we, pc_load_target, ifid_we, ifid_flush, idex_bubble}
  function automatic logic [4:0] vec(input logic hz, input logic tk);
    if (tk)      return 5'b11011;
    else if (hz) return 5'b00001;
    else         return 5'b10100;
  endfunction

  function automatic logic old_hit(input logic [REG_W-1:0] r, input logic u,
                                   input logic [REG_W-1:0] rd, input logic wen);
    return u && (r != 0) && ((wen && r == rd) || r == m_h1 || r == m_h2);
  endfunction

  // Driver: applies one cycle of inputs and pushes the expected vectors
  task automatic step(input logic [REG_W-1:0] rs1, input logic [REG_W-1:0] rs2,
                      input logic u1, input logic u2,
                      input logic [REG_W-1:0] rd, input logic wen, input logic mrd,
                      input logic tk, input string tag);
    logic fh, nh;
    @(negedge clk);
    if (!rst_n) begin
      m_prev = 1'b0; m_h1 = '0; m_h2 = '0;
    end
    id_rs1 = rs1; id_rs2 = rs2; id_use_rs1 = u1; id_use_rs2 = u2;
    ex_rd = rd; ex_wen = wen; ex_mem_read = mrd; ex_taken = tk;
    fh = mrd && wen && (rd != 0) && ((u1 && rs1 == rd) || (u2 && rs2 == rd)) && !m_prev;
    nh = old_hit(rs1, u1, rd, wen) || old_hit(rs2, u2, rd, wen);
    qf.push_back(vec(fh, tk));
    qn.push_back(vec(nh, tk));
    qt.push_back(tag);
    if (rst_n) begin
      m_prev = fh && !tk;
      m_h2   = m_h1;
      m_h1   = wen ? rd : '0;
    end
  endtask

  task automatic idle(input string tag);
    step(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares the outputs in the same half-cycle the driver set up
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (qf.size() > 0) begin
        logic [4:0] ef, en, af, an;
        string t;
        ef = qf.pop_front(); en = qn.pop_front(); t = qt.pop_front();
        af = {f_pc_we, f_tgt, f_ifid_we, f_flush, f_bub};
        an = {n_pc_we, n_tgt, n_ifid_we, n_flush, n_bub};
        checks += 2;
        if (af !== ef) begin
          fails++;
          $display("FAIL %s forwarding: got %b expected %b", t, af, ef);
        end
        if (an !== en) begin
          fails++;
          $display("FAIL %s no-forward: got %b expected %b", t, an, en);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    m_prev = 1'b0; m_h1 = '0; m_h2 = '0;
    id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0;
    ex_rd = '0; ex_wen = 0; ex_mem_read = 0; ex_taken = 0;

    // R11: in reset the guard stays clear, so consecutive holds appear
    step(5'd5, 5'd0, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0, "R11 reset hold a");
    step(5'd5, 5'd0, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0, "R11 reset hold b");
    @(negedge clk); rst_n = 1'b1;
    idle("R1 after reset a");
    idle("R1 after reset b");
    idle("R1 after reset c");
    // R11: destination seen during reset is not remembered
    step(5'd5, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, "R11 history cleared");

    // R2 / R3: load-use on rs1, then the same match again
    step(5'd7, 5'd2, 1'b1, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, "R2 load-use rs1");
    step(5'd7, 5'd2, 1'b1, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, "R3 second cycle");
    idle("R1 drain a"); idle("R1 drain b"); idle("R1 drain c");
    // R2 on rs2
    step(5'd1, 5'd12, 1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 1'b0, "R2 load-use rs2");
    idle("R1 drain d"); idle("R1 drain e"); idle("R1 drain f");

    // R4 / R7 / R8: non-load producer, then it ages through the history
    step(5'd9, 5'd0, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, 1'b0, "R4 alu producer");
    step(5'd9, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, "R7 one cycle old");
    step(5'd9, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, "R7 two cycles old");
    step(5'd9, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, "R8 three cycles old");

    // R8: non-writing execute instruction is not recorded
    step(5'd0, 5'd0, 1'b0, 1'b0, 5'd6, 1'b0, 1'b0, 1'b0, "R8 no write");
    step(5'd6, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, "R8 no write follow");

    // R5: register zero
    step(5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, "R5 zero register");
    idle("R1 drain g"); idle("R1 drain h");

    // R6: matching field that is not read
    step(5'd4, 5'd4, 1'b0, 1'b0, 5'd4, 1'b1, 1'b1, 1'b0, "R6 unused sources");
    step(5'd4, 5'd3, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, "R6 unused rs1 aged");
    idle("R1 drain i"); idle("R1 drain j");

    // R9: plain taken branch
    step(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, "R9 taken");
    // R10: taken with load-use, then the load-use alone
    step(5'd8, 5'd0, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b1, "R10 squash over hold");
    step(5'd8, 5'd0, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, "R10 hold after squash");
    step(5'd8, 5'd0, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, "R3 guard after R10");
    idle("R1 end a"); idle("R1 end b");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule